// File: doc/BRIEF.md
# Segment Descriptor Fetch and Validation

This block turns a 16-bit segment selector into a checked segment description. The caller names a destination (code, stack or data register), supplies the current privilege level, and pulses `start`. The block first decides which descriptor table the selector points into and whether the entry lies inside that table's limit. If it does, the block reads the 8-byte entry over a 32-bit read port as two words. It then applies the rule set for that destination and reports either the assembled base, the expanded limit and the raw attribute word, or a fault class with an error code.

Table base and limit registers and the privilege level are plain inputs and must stay stable while an operation runs. A null selector never touches memory. Writing the result into a segment cache is left to the caller.

Top module: `seg_desc_loader`

## Requirements
- R1: Selector bit 2 set picks the local table (`ldt_base`/`ldt_limit`); clear picks the global table. The entry byte offset is the selector with bits 2:0 cleared, added to the chosen table base.
- R2: If offset+7 is greater than the chosen table limit, the result is fault class 1 (invalid-task) and no memory read is issued.
- R3: A non-null, in-bounds selector causes exactly two read handshakes (`mem_rd_req` and `mem_rd_valid` both high at a clock edge): the low word at the entry address, then the high word at that address plus 4. While `mem_rd_valid` is low, the request and its address are held.
- R4: `seg_base` is low-word bits 31:16 in base bits 15:0, high-word bits 7:0 in base bits 23:16, and high-word bits 31:24 in base bits 31:24.
- R5: `seg_limit` is {high-word bits 19:16, low-word bits 15:0}. When high-word bit 23 (granularity) is set, the value is shifted left by 12 and bits 11:0 are filled with ones.
- R6: A selector with bits 15:2 all zero is null and is never read. For a data destination (`dst` = 2 or 3) it is accepted with fault 0 and all-zero outputs. For code (`dst` = 0) or stack (`dst` = 1) it gives fault 1.
- R7: For code, the descriptor must be code (high-word bit 11 set) with DPL (high-word bits 14:13) equal to the selector RPL (bits 1:0). A conforming descriptor (bit 10) with DPL greater than RPL also faults. Any violation gives fault 1.
- R8: For stack, the descriptor must be data (bit 11 clear) with the writable bit (bit 9) set, and DPL must equal both `cpl` and RPL. Otherwise fault 1.
- R9: For data, code without the readable bit (bit 9) gives fault 1. When the 4-bit type (bits 11:8) is below 12, DPL less than `cpl` or less than RPL gives fault 1. Conforming code skips the privilege test.
- R10: A descriptor with the system bit (bit 12) clear gives fault 1. The present bit (bit 15) is tested after every other check and, if clear, gives fault 2 (not-present). On any fault, `err_code` is the selector with bits 1:0 cleared and base, limit and attribute read zero. With no fault, `err_code` is zero and `seg_attr` is the high word.
- R11: `done` is high for exactly one cycle per accepted `start`. A `start` that arrives while an operation is in flight is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (accepted when idle) |
| sel | input | 16 | Segment selector |
| dst | input | 2 | Destination: 0 code, 1 stack, 2/3 data |
| cpl | input | 2 | Current privilege level |
| gdt_base | input | ADDR_W | Global table base address |
| gdt_limit | input | ADDR_W | Global table limit |
| ldt_base | input | ADDR_W | Local table base address |
| ldt_limit | input | ADDR_W | Local table limit |
| mem_rd_req | output | 1 | Read request, held until accepted |
| mem_rd_addr | output | ADDR_W | Read address |
| mem_rd_valid | input | 1 | Read data valid / request accepted |
| mem_rd_data | input | 32 | Read data |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 2 | 0 none, 1 invalid-task, 2 not-present |
| err_code | output | 16 | Faulting selector with bits 1:0 cleared |
| seg_base | output | 32 | Assembled segment base |
| seg_limit | output | 32 | Expanded segment limit |
| seg_attr | output | 32 | Descriptor high word |

## Verification
A sequencer stuck in a read phase shows at once as a missing `done` pulse or a third read handshake, and a wrongly latched low word shows in the base or limit reported on the same `done` cycle. Check-ordering mistakes, such as testing presence before privilege, appear as fault class 2 where class 1 is due, on the first descriptor that breaks both rules. A bad null or bounds decision shows up within two cycles of `start`, as a read handshake where none is allowed. Stalled read responses and a `start` that arrives mid-operation are exercised to expose a request that drops or moves early.

// File: rtl/seg_chk_pkg.sv
package seg_chk_pkg;

    localparam int DESC_W = 32;

    // bit positions inside the access byte (high word bits 15:8)
    localparam int AB_PRESENT = 7;
    localparam int AB_DPL_HI  = 6;
    localparam int AB_DPL_LO  = 5;
    localparam int AB_SYS     = 4;
    localparam int AB_CODE    = 3;
    localparam int AB_CONF    = 2;
    localparam int AB_RW      = 1;

    // granularity bit inside the high word
    localparam int HW_GRAN    = 23;

    typedef enum logic [1:0] {
        DST_CODE  = 2'd0,
        DST_STACK = 2'd1,
        DST_DATA  = 2'd2,
        DST_DATA2 = 2'd3
    } dst_e;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'd0,
        FLT_TASK   = 2'd1,
        FLT_ABSENT = 2'd2
    } flt_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_RD_LO,
        ST_RD_HI,
        ST_DONE
    } fetch_st_e;

    typedef struct packed {
        logic [DESC_W-1:0] base;
        logic [DESC_W-1:0] limit;
    } seg_geom_t;

    function automatic seg_geom_t unpack_geom(input logic [DESC_W-1:0] lo,
                                              input logic [DESC_W-1:0] hi);
        seg_geom_t g;
        logic [19:0] raw;
        g.base = {hi[31:24], hi[7:0], lo[31:16]};
        raw    = {hi[19:16], lo[15:0]};
        if (hi[HW_GRAN])
            g.limit = {raw, 12'hfff};
        else
            g.limit = {12'h000, raw};
        return g;
    endfunction

endpackage

// File: rtl/seg_sel_decode.sv
module seg_sel_decode
    import seg_chk_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [13:0]       sel_upper,   // selector bits 15:2
    input  logic [ADDR_W-1:0] gdt_base,
    input  logic [ADDR_W-1:0] gdt_limit,
    input  logic [ADDR_W-1:0] ldt_base,
    input  logic [ADDR_W-1:0] ldt_limit,
    output logic              is_null,
    output logic              out_of_bounds,
    output logic [ADDR_W-1:0] entry_addr
);
    localparam int IDX_W = 16;

    logic              use_local;
    logic [IDX_W-1:0]  byte_idx;
    logic [ADDR_W-1:0] tbl_base;
    logic [ADDR_W-1:0] tbl_limit;
    logic [ADDR_W-1:0] last_byte;

    assign use_local     = sel_upper[0];
    assign byte_idx      = {sel_upper[13:1], 3'b000};
    assign is_null       = (sel_upper == '0);
    assign tbl_base      = use_local ? ldt_base  : gdt_base;
    assign tbl_limit     = use_local ? ldt_limit : gdt_limit;
    assign last_byte     = ADDR_W'(byte_idx) + ADDR_W'(7);
    assign out_of_bounds = last_byte > tbl_limit;
    assign entry_addr    = tbl_base + ADDR_W'(byte_idx);

endmodule

// File: rtl/seg_rule_check.sv
module seg_rule_check
    import seg_chk_pkg::*;
(
    input  dst_e        dst,
    input  logic [1:0]  cpl,
    input  logic [1:0]  rpl,
    input  logic [7:0]  acc,          // high word bits 15:8
    input  logic        is_null,
    input  logic        out_of_bounds,
    output flt_e        verdict
);
    logic [1:0] dpl;
    logic       is_code;
    logic       priv_bad;

    assign dpl     = acc[AB_DPL_HI:AB_DPL_LO];
    assign is_code = acc[AB_CODE];

    always_comb begin
        priv_bad = 1'b0;
        case (dst)
            DST_CODE: begin
                if (!is_code)                  priv_bad = 1'b1;
                if (dpl != rpl)                priv_bad = 1'b1;
                if (acc[AB_CONF] && dpl > rpl) priv_bad = 1'b1;
            end
            DST_STACK: begin
                if (is_code || !acc[AB_RW])    priv_bad = 1'b1;
                if (dpl != cpl || dpl != rpl)  priv_bad = 1'b1;
            end
            default: begin
                if (is_code && !acc[AB_RW])    priv_bad = 1'b1;
                // type below 12: data or non-conforming code
                if (!(is_code && acc[AB_CONF]))
                    if (dpl < cpl || dpl < rpl) priv_bad = 1'b1;
            end
        endcase
    end

    always_comb begin
        verdict = FLT_NONE;
        if (is_null) begin
            if (dst == DST_CODE || dst == DST_STACK)
                verdict = FLT_TASK;
        end else if (out_of_bounds) begin
            verdict = FLT_TASK;
        end else if (!acc[AB_SYS]) begin
            verdict = FLT_TASK;
        end else if (priv_bad) begin
            verdict = FLT_TASK;
        end else if (!acc[AB_PRESENT]) begin
            verdict = FLT_ABSENT;
        end
    end

endmodule

// File: rtl/seg_fetch_ctrl.sv
module seg_fetch_ctrl
    import seg_chk_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [15:0]       sel,
    input  logic [1:0]        dst,
    input  logic [1:0]        cpl,
    input  logic              skip_fetch,
    input  logic [ADDR_W-1:0] entry_addr,
    output logic              mem_rd_req,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rd_valid,
    input  logic [DESC_W-1:0] mem_rd_data,
    output logic [15:0]       sel_q,
    output dst_e              dst_q,
    output logic [1:0]        cpl_q,
    output logic [DESC_W-1:0] lo_q,
    output logic              finish,
    output logic              done
);
    localparam logic [ADDR_W-1:0] HI_OFS = ADDR_W'(4);

    fetch_st_e         st;
    logic [ADDR_W-1:0] addr_q;

    assign mem_rd_req  = (st == ST_RD_LO) || (st == ST_RD_HI);
    assign mem_rd_addr = (st == ST_RD_HI) ? addr_q + HI_OFS : addr_q;
    assign finish      = ((st == ST_LOOKUP) && skip_fetch) ||
                         ((st == ST_RD_HI) && mem_rd_valid);
    assign done        = (st == ST_DONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            sel_q  <= '0;
            dst_q  <= DST_DATA;
            cpl_q  <= '0;
            lo_q   <= '0;
            addr_q <= '0;
        end else begin
            case (st)
                ST_IDLE: if (start) begin
                    sel_q <= sel;
                    dst_q <= dst_e'(dst);
                    cpl_q <= cpl;
                    st    <= ST_LOOKUP;
                end
                ST_LOOKUP: begin
                    addr_q <= entry_addr;
                    st     <= skip_fetch ? ST_DONE : ST_RD_LO;
                end
                ST_RD_LO: if (mem_rd_valid) begin
                    lo_q <= mem_rd_data;
                    st   <= ST_RD_HI;
                end
                ST_RD_HI: if (mem_rd_valid) st <= ST_DONE;
                default:  st <= ST_IDLE;
            endcase
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);                                                   // R11

    AST_HI_FOLLOWS_LO: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_req && mem_rd_valid && st == ST_RD_LO) |=>
        (mem_rd_req && mem_rd_addr == $past(mem_rd_addr) + HI_OFS));       // R3

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_req && !mem_rd_valid) |=>
        (mem_rd_req && $stable(mem_rd_addr)));                             // R3

endmodule

// File: rtl/seg_desc_loader.sv
module seg_desc_loader
    import seg_chk_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [15:0]       sel,
    input  logic [1:0]        dst,
    input  logic [1:0]        cpl,
    input  logic [ADDR_W-1:0] gdt_base,
    input  logic [ADDR_W-1:0] gdt_limit,
    input  logic [ADDR_W-1:0] ldt_base,
    input  logic [ADDR_W-1:0] ldt_limit,
    output logic              mem_rd_req,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rd_valid,
    input  logic [31:0]       mem_rd_data,
    output logic              done,
    output logic [1:0]        fault,
    output logic [15:0]       err_code,
    output logic [31:0]       seg_base,
    output logic [31:0]       seg_limit,
    output logic [31:0]       seg_attr
);
    logic [15:0]       sel_q;
    dst_e              dst_q;
    logic [1:0]        cpl_q;
    logic [DESC_W-1:0] lo_q;
    logic              finish;
    logic              is_null;
    logic              oob;
    logic [ADDR_W-1:0] entry_addr;
    flt_e              verdict;
    seg_geom_t         geom;

    seg_sel_decode #(.ADDR_W(ADDR_W)) u_decode (
        .sel_upper     (sel_q[15:2]),
        .gdt_base      (gdt_base),
        .gdt_limit     (gdt_limit),
        .ldt_base      (ldt_base),
        .ldt_limit     (ldt_limit),
        .is_null       (is_null),
        .out_of_bounds (oob),
        .entry_addr    (entry_addr)
    );

    seg_fetch_ctrl #(.ADDR_W(ADDR_W)) u_fetch (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .sel          (sel),
        .dst          (dst),
        .cpl          (cpl),
        .skip_fetch   (is_null || oob),
        .entry_addr   (entry_addr),
        .mem_rd_req   (mem_rd_req),
        .mem_rd_addr  (mem_rd_addr),
        .mem_rd_valid (mem_rd_valid),
        .mem_rd_data  (mem_rd_data),
        .sel_q        (sel_q),
        .dst_q        (dst_q),
        .cpl_q        (cpl_q),
        .lo_q         (lo_q),
        .finish       (finish),
        .done         (done)
    );

    seg_rule_check u_rules (
        .dst           (dst_q),
        .cpl           (cpl_q),
        .rpl           (sel_q[1:0]),
        .acc           (mem_rd_data[15:8]),
        .is_null       (is_null),
        .out_of_bounds (oob),
        .verdict       (verdict)
    );

    assign geom = unpack_geom(lo_q, mem_rd_data);

    always_ff @(posedge clk) begin
        if (rst) begin
            fault     <= FLT_NONE;
            err_code  <= '0;
            seg_base  <= '0;
            seg_limit <= '0;
            seg_attr  <= '0;
        end else if (finish) begin
            fault <= verdict;
            if (verdict == FLT_NONE && !is_null) begin
                err_code  <= '0;
                seg_base  <= geom.base;
                seg_limit <= geom.limit;
                seg_attr  <= mem_rd_data;
            end else begin
                err_code  <= (verdict == FLT_NONE) ? 16'h0000 : {sel_q[15:2], 2'b00};
                seg_base  <= '0;
                seg_limit <= '0;
                seg_attr  <= '0;
            end
        end
    end

    AST_FAULT_ZEROES: assert property (@(posedge clk) disable iff (rst)
        (done && fault != FLT_NONE) |->
        (seg_base == '0 && seg_limit == '0 && seg_attr == '0));            // R10

    AST_ERR_LOW_BITS: assert property (@(posedge clk) disable iff (rst)
        done |-> (err_code[1:0] == 2'b00));                                // R10

    AST_GRAN_FILL: assert property (@(posedge clk) disable iff (rst)
        (done && fault == FLT_NONE && seg_attr[HW_GRAN]) |->
        (seg_limit[11:0] == 12'hfff));                                     // R5

    AST_OK_PRESENT: assert property (@(posedge clk) disable iff (rst)
        (done && fault == FLT_NONE && seg_attr != '0) |->
        (seg_attr[15] && seg_attr[12]));                                   // R10

endmodule

// File: tb/seg_desc_loader_bench.sv
`timescale 1ns/1ps
module seg_desc_loader_bench;

    localparam int AW = 32;
    localparam logic [31:0] GBASE = 32'h0000_0100;
    localparam logic [31:0] GLIM  = 32'h0000_003F;
    localparam logic [31:0] LBASE = 32'h0000_0200;
    localparam logic [31:0] LLIM  = 32'h0000_0017;

    typedef struct packed {
        logic [15:0] sel;
        logic [1:0]  dst;
        logic [1:0]  cpl;
        logic [1:0]  flt;
        logic [31:0] base;
        logic [31:0] lim;
        logic [1:0]  nrd;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VECS [NV] = '{
        '{16'h0008, 2'd0, 2'd0, 2'd0, 32'h12345678, 32'h000ABCDE, 2'd2, 8'd7},  // R7 R4
        '{16'h000B, 2'd0, 2'd0, 2'd1, 32'h0, 32'h0, 2'd2, 8'd7},                // R7 dpl!=rpl
        '{16'h0010, 2'd1, 2'd0, 2'd0, 32'h00A0B0C0, 32'h00012FFF, 2'd2, 8'd8},  // R8 R5
        '{16'h0011, 2'd1, 2'd1, 2'd1, 32'h0, 32'h0, 2'd2, 8'd8},                // R8 dpl!=rpl
        '{16'h0008, 2'd1, 2'd0, 2'd1, 32'h0, 32'h0, 2'd2, 8'd8},                // R8 code
        '{16'h0006, 2'd1, 2'd2, 2'd1, 32'h0, 32'h0, 2'd2, 8'd8},                // R8 read-only
        '{16'h001B, 2'd1, 2'd3, 2'd0, 32'hFF000000, 32'hFFFFFFFF, 2'd2, 8'd5},  // R5 R8
        '{16'h0010, 2'd2, 2'd3, 2'd1, 32'h0, 32'h0, 2'd2, 8'd9},                // R9 dpl<cpl
        '{16'h0013, 2'd2, 2'd0, 2'd1, 32'h0, 32'h0, 2'd2, 8'd9},                // R9 dpl<rpl
        '{16'h0020, 2'd2, 2'd3, 2'd0, 32'h00001000, 32'h0000FFFF, 2'd2, 8'd9},  // R9 conforming
        '{16'h002B, 2'd2, 2'd3, 2'd1, 32'h0, 32'h0, 2'd2, 8'd9},                // R9 exec-only
        '{16'h0030, 2'd2, 2'd0, 2'd2, 32'h0, 32'h0, 2'd2, 8'd10},               // R10 absent
        '{16'h0033, 2'd3, 2'd0, 2'd1, 32'h0, 32'h0, 2'd2, 8'd10},               // R10 order
        '{16'h0038, 2'd2, 2'd0, 2'd1, 32'h0, 32'h0, 2'd2, 8'd10},               // R10 system
        '{16'h0000, 2'd2, 2'd0, 2'd0, 32'h0, 32'h0, 2'd0, 8'd6},                // R6 null data
        '{16'h0003, 2'd0, 2'd0, 2'd1, 32'h0, 32'h0, 2'd0, 8'd6},                // R6 null code
        '{16'h0001, 2'd1, 2'd0, 2'd1, 32'h0, 32'h0, 2'd0, 8'd6},                // R6 null stack
        '{16'h0040, 2'd2, 2'd0, 2'd1, 32'h0, 32'h0, 2'd0, 8'd2},                // R2 global
        '{16'h001F, 2'd2, 2'd3, 2'd1, 32'h0, 32'h0, 2'd0, 8'd2},                // R2 local
        '{16'h000F, 2'd2, 2'd3, 2'd0, 32'h55AA0000, 32'h0000FFFF, 2'd2, 8'd1},  // R1
        '{16'h0017, 2'd0, 2'd3, 2'd0, 32'h00000000, 32'hFFFFFFFF, 2'd2, 8'd1},  // R1 R7
        '{16'h0020, 2'd0, 2'd0, 2'd0, 32'h00001000, 32'h0000FFFF, 2'd2, 8'd7},  // R7 conf ok
        '{16'h0023, 2'd0, 2'd0, 2'd1, 32'h0, 32'h0, 2'd2, 8'd7},                // R7 conf dpl<rpl
        '{16'h0017, 2'd2, 2'd3, 2'd0, 32'h00000000, 32'hFFFFFFFF, 2'd2, 8'd9}   // R9 readable code
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [15:0]   sel = '0;
    logic [1:0]    dst = '0;
    logic [1:0]    cpl = '0;
    logic          mem_rd_req;
    logic [AW-1:0] mem_rd_addr;
    logic          mem_rd_valid;
    logic [31:0]   mem_rd_data;
    logic          done;
    logic [1:0]    fault;
    logic [15:0]   err_code;
    logic [31:0]   seg_base, seg_limit, seg_attr;

    logic [31:0]   mem [256];
    logic          stall_en = 1'b0;
    logic          stall = 1'b0;
    int            rd_cnt = 0;
    logic [31:0]   a_prev = '0, a_last = '0;
    int            checks = 0;
    int            fails = 0;

    always #10 clk = ~clk;

    assign mem_rd_valid = mem_rd_req && !stall;
    assign mem_rd_data  = mem[mem_rd_addr[9:2]];

    always @(posedge clk) begin
        stall <= stall_en ? ~stall : 1'b0;
        if (mem_rd_req && mem_rd_valid) begin
            rd_cnt <= rd_cnt + 1;
            a_prev <= a_last;
            a_last <= mem_rd_addr;
        end
    end

    seg_desc_loader #(.ADDR_W(AW)) u_seg_desc_loader (
        .clk(clk), .rst(rst), .start(start), .sel(sel), .dst(dst), .cpl(cpl),
        .gdt_base(GBASE), .gdt_limit(GLIM), .ldt_base(LBASE), .ldt_limit(LLIM),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
        .done(done), .fault(fault), .err_code(err_code),
        .seg_base(seg_base), .seg_limit(seg_limit), .seg_attr(seg_attr)
    );

    task automatic chk(input bit ok, input int req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic put_desc(input int slot_addr, input logic [31:0] b,
                            input logic [19:0] l, input logic [3:0] ty,
                            input logic s, input logic [1:0] dpl,
                            input logic p, input logic g);
        mem[slot_addr[9:2]]       = {b[15:0], l[15:0]};
        mem[slot_addr[9:2] + 1]   = {b[31:24], g, 1'b1, 2'b00, l[19:16],
                                     p, dpl, s, ty, b[23:16]};
    endtask

    // runs one operation, returns read count; outputs sampled on done
    task automatic run_op(input logic [15:0] s, input logic [1:0] d,
                          input logic [1:0] c, output int nrd, output bit seen);
        int base_cnt;
        base_cnt = rd_cnt;
        seen = 1'b0;
        @(negedge clk);
        sel = s; dst = d; cpl = c; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 60 && !seen; i++) begin
            if (done) seen = 1'b1;
            else @(negedge clk);
        end
        nrd = rd_cnt - base_cnt;
    endtask

    task automatic check_vec(input vec_t v);
        int nrd;
        bit seen;
        logic [31:0] lo_a, ex_attr;
        int req;
        req = int'(v.req);
        run_op(v.sel, v.dst, v.cpl, nrd, seen);
        chk(seen, 11, "done seen", {31'b0, seen}, 32'd1);
        chk(fault == v.flt, req, "fault", {30'b0, fault}, {30'b0, v.flt});
        chk(err_code == ((v.flt != 0) ? (v.sel & 16'hFFFC) : 16'h0), 10, "err_code",
            {16'b0, err_code}, {16'b0, (v.flt != 0) ? (v.sel & 16'hFFFC) : 16'h0});
        chk(seg_base == v.base, 4, "base", seg_base, v.base);
        chk(seg_limit == v.lim, 5, "limit", seg_limit, v.lim);
        chk(nrd == int'(v.nrd), 3, "read count", nrd, {30'b0, v.nrd});
        lo_a = (v.sel[2] ? LBASE : GBASE) + {16'b0, v.sel & 16'hFFF8};
        if (v.nrd == 2) begin
            chk(a_prev == lo_a, 1, "low word addr", a_prev, lo_a);
            chk(a_last == lo_a + 4, 3, "high word addr", a_last, lo_a + 4);
        end
        ex_attr = (v.flt == 0 && v.nrd == 2) ? mem[lo_a[9:2] + 1] : 32'h0;
        chk(seg_attr == ex_attr, 10, "attr", seg_attr, ex_attr);
        @(negedge clk);
        chk(done == 1'b0, 11, "done one cycle", {31'b0, done}, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL R11 watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'h0;
        // global table at 0x100, slot n at 0x100 + 8n
        put_desc(32'h108, 32'h12345678, 20'hABCDE, 4'hA, 1, 2'd0, 1, 0);
        put_desc(32'h110, 32'h00A0B0C0, 20'h00012, 4'h2, 1, 2'd0, 1, 1);
        put_desc(32'h118, 32'hFF000000, 20'hFFFFF, 4'h2, 1, 2'd3, 1, 1);
        put_desc(32'h120, 32'h00001000, 20'h0FFFF, 4'hE, 1, 2'd0, 1, 0);
        put_desc(32'h128, 32'h00002000, 20'h0FFFF, 4'h8, 1, 2'd3, 1, 0);
        put_desc(32'h130, 32'h00003000, 20'h0FFFF, 4'h2, 1, 2'd0, 0, 0);
        put_desc(32'h138, 32'h00004000, 20'h0FFFF, 4'h2, 0, 2'd0, 1, 0);
        // local table at 0x200
        put_desc(32'h200, 32'h00000800, 20'h00001, 4'h0, 1, 2'd2, 1, 0);
        put_desc(32'h208, 32'h55AA0000, 20'h0FFFF, 4'h2, 1, 2'd3, 1, 0);
        put_desc(32'h210, 32'h00000000, 20'hFFFFF, 4'hA, 1, 2'd3, 1, 1);

        repeat (3) @(negedge clk);
        // reset state
        chk(done == 1'b0, 11, "reset done", {31'b0, done}, 32'd0);
        chk(mem_rd_req == 1'b0, 3, "reset req", {31'b0, mem_rd_req}, 32'd0);
        chk(fault == 2'd0, 10, "reset fault", {30'b0, fault}, 32'd0);
        rst = 1'b0;

        for (int k = 0; k < NV; k++) check_vec(VECS[k]);

        // R3: stalled read responses do not disturb the fetch
        stall_en = 1'b1;
        check_vec(VECS[0]);
        check_vec(VECS[19]);
        stall_en = 1'b0;

        // R11: start while busy is ignored
        begin
            int base_cnt;
            base_cnt = rd_cnt;
            @(negedge clk);
            sel = 16'h0010; dst = 2'd2; cpl = 2'd0; start = 1'b1;
            @(negedge clk);
            sel = 16'h0030;
            repeat (2) @(negedge clk);
            start = 1'b0;
            while (!done) @(negedge clk);
            chk(fault == 2'd0, 11, "busy start fault", {30'b0, fault}, 32'd0);
            chk(seg_base == 32'h00A0B0C0, 11, "busy start base", seg_base, 32'h00A0B0C0);
            repeat (4) @(negedge clk);
            chk(done == 1'b0, 11, "no second done", {31'b0, done}, 32'd0);
            chk(rd_cnt - base_cnt == 2, 11, "busy start reads", rd_cnt - base_cnt, 32'd2);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule